// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the device side of a serial flash memory, limited to its read path. An external master drives chip-select, serial clock and serial data in. The engine samples them with its own system clock, decodes an 8-bit command and a 24-bit start address, and then sends data bytes back on the serial output without a break until the master raises chip-select. The bytes come from a simple read port that an external array answers, so the storage sits outside the engine.

Two read commands are recognised. The plain read starts output right after the address. The fast read first swallows a fixed number of don't-care clocks. While one byte shifts out, the next byte is already fetched. The pointer steps through the array and returns to zero after the top address. The serial clock may idle low or high. Any other command makes the engine stay silent for the rest of that select period.

Top module: `flash_read_engine`

## Requirements
- R1: After reset, and within 8 system clocks after chip-select goes high, so_oe is 0 (serial output released). mem_rd_en is 0 after reset.
- R2: Command byte 8'h03 (plain read), sent MSB first on rising edges, is followed by 24 address bits, MSB first. The first data bit appears after the falling edge that follows the 32nd rising edge.
- R3: Command byte 8'h0B (fast read) adds 8 rising edges after the address whose input values are ignored. The first data bit appears after the falling edge that follows the 40th rising edge.
- R4: Only the low AW address bits (AW = 20 for the default top address 20'hFFFFF) form the start pointer. Bits 23..AW have no effect on the data returned.
- R5: Each data byte is sent MSB first, one bit per serial clock, and consecutive bytes come from consecutive addresses with no idle clocks between them.
- R6: After the byte at the top address, the next byte comes from address 0.
- R7: so_oe stays 0 during the command, address and dummy phases.
- R8: so_d changes only after a falling serial-clock edge. It is stable while the clock is high, with the clock idling either low (mode 0) or high (mode 3).
- R9: Any other command byte keeps so_oe at 0 and issues no memory reads until chip-select rises. The next transaction then decodes normally.
- R10: Raising chip-select in the middle of a byte ends the read. The following transaction starts cleanly from its own address.
- R11: The engine issues one single-cycle mem_rd_en pulse for the start address and one more each time a byte is loaded for output. It takes mem_rdata in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the master, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the device |
| so_d | output | 1 | Serial data out of the device |
| so_oe | output | 1 | Output enable for so_d; 0 means high-impedance |
| mem_rd_en | output | 1 | Single-cycle read request to the array |
| mem_addr | output | AW (20) | Byte address of the read request |
| mem_rdata | input | 8 | Array byte, valid the cycle after mem_rd_en |

## Verification
A wrong phase counter shows up as a byte shifted by some bits, or as so_oe rising during the header. Both appear on the first data byte the master collects after the header. A wrong pointer shows as a byte that differs from the address-derived pattern at the next byte boundary, or at the wrap point when the top address is crossed. A stuck decoder state after a bad command, or after an aborted read, shows on the very next transaction as missing or misplaced data. The count of read pulses at the array port also differs at once when a fetch is doubled or lost.

// File: rtl/frd_pkg.sv
package frd_pkg;

   typedef enum logic [2:0] {
      ST_OPC   = 3'd0,
      ST_ADDR  = 3'd1,
      ST_DUMMY = 3'd2,
      ST_DATA  = 3'd3,
      ST_SKIP  = 3'd4
   } frd_state_e;

   localparam int          CMD_BITS  = 8;
   localparam int          WIRE_ABITS = 24;
   localparam logic [7:0]  CMD_PLAIN = 8'h03;
   localparam logic [7:0]  CMD_FAST  = 8'h0B;

endpackage

// File: rtl/frd_pin_sync.sv
module frd_pin_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic cs_q,
   output logic si_q,
   output logic sck_rise,
   output logic sck_fall
);

   logic sck_q;
   logic sck_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cs_q  = cs_n;
         assign sck_q = sck;
         assign si_q  = si;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] cs_p;
         logic [SYNC_STAGES-1:0] sck_p;
         logic [SYNC_STAGES-1:0] si_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_p  <= '1;
               sck_p <= '0;
               si_p  <= '0;
            end else begin
               cs_p[0]  <= cs_n;
               sck_p[0] <= sck;
               si_p[0]  <= si;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  cs_p[i]  <= cs_p[i-1];
                  sck_p[i] <= sck_p[i-1];
                  si_p[i]  <= si_p[i-1];
               end
            end
         end
         assign cs_q  = cs_p[SYNC_STAGES-1];
         assign sck_q = sck_p[SYNC_STAGES-1];
         assign si_q  = si_p[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_q;
   end

   assign sck_rise = sck_q & ~sck_prev;
   assign sck_fall = ~sck_q & sck_prev;

endmodule

// File: rtl/frd_header.sv
module frd_header
   import frd_pkg::*;
#(
   parameter int DUMMY_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  rise,
   input  logic                  si_q,
   output frd_state_e            state,
   output logic                  addr_load,
   output logic [WIRE_ABITS-1:0] addr_word
);

   localparam int MAXCNT = (DUMMY_BITS > WIRE_ABITS) ? DUMMY_BITS : WIRE_ABITS;
   localparam int CW     = $clog2(MAXCNT + 1);

   logic [CW-1:0]         cnt;
   logic [WIRE_ABITS-1:0] sh;
   logic                  fast_q;
   logic [CMD_BITS-1:0]   cmd_word;

   assign cmd_word  = {sh[CMD_BITS-2:0], si_q};
   assign addr_word = {sh[WIRE_ABITS-2:0], si_q};
   assign addr_load = rise && !clr && (state == ST_ADDR) && (cnt == CW'(WIRE_ABITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_OPC;
         cnt    <= '0;
         sh     <= '0;
         fast_q <= 1'b0;
      end else if (clr) begin
         state  <= ST_OPC;
         cnt    <= '0;
         fast_q <= 1'b0;
      end else if (rise) begin
         sh <= {sh[WIRE_ABITS-2:0], si_q};
         case (state)
            ST_OPC: begin
               if (cnt == CW'(CMD_BITS - 1)) begin
                  cnt <= '0;
                  if (cmd_word == CMD_PLAIN) begin
                     state  <= ST_ADDR;
                     fast_q <= 1'b0;
                  end else if (cmd_word == CMD_FAST) begin
                     state  <= ST_ADDR;
                     fast_q <= 1'b1;
                  end else begin
                     state <= ST_SKIP;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ADDR: begin
               if (cnt == CW'(WIRE_ABITS - 1)) begin
                  cnt   <= '0;
                  state <= fast_q ? ST_DUMMY : ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DUMMY: begin
               if (cnt == CW'(DUMMY_BITS - 1)) begin
                  cnt   <= '0;
                  state <= ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               cnt <= cnt;
            end
         endcase
      end
   end

endmodule

// File: rtl/frd_stream.sv
module frd_stream #(
   parameter int unsigned TOP_ADDR = 32'h000F_FFFF,
   parameter int          AW       = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fall,
   input  logic          active,
   input  logic          addr_load,
   input  logic [AW-1:0] load_addr,
   input  logic [7:0]    mem_rdata,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   output logic          so_d,
   output logic          so_oe,
   output logic [AW-1:0] ptr
);

   logic [AW-1:0] ptr_ld;
   logic [AW-1:0] ptr_nxt;
   logic [7:0]    nbuf;
   logic [7:0]    sr;
   logic [2:0]    bitn;
   logic          pend;
   logic          take;

   generate
      if (TOP_ADDR == (2 ** AW) - 1) begin : g_pow2
         assign ptr_ld  = load_addr;
         assign ptr_nxt = ptr + 1'b1;
      end else begin : g_odd
         assign ptr_ld  = (load_addr > AW'(TOP_ADDR)) ? load_addr - AW'(TOP_ADDR + 1) : load_addr;
         assign ptr_nxt = (ptr == AW'(TOP_ADDR)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   assign take     = active && fall && (!so_oe || bitn == 3'd7);
   assign mem_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         mem_rd_en <= 1'b0;
         pend      <= 1'b0;
         nbuf      <= '0;
      end else if (clr) begin
         mem_rd_en <= 1'b0;
         pend      <= 1'b0;
      end else begin
         mem_rd_en <= addr_load | take;
         pend      <= mem_rd_en;
         if (pend)           nbuf <= mem_rdata;
         if (addr_load)      ptr  <= ptr_ld;
         else if (take)      ptr  <= ptr_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so_d  <= 1'b0;
         so_oe <= 1'b0;
         sr    <= '0;
         bitn  <= '0;
      end else if (clr) begin
         so_oe <= 1'b0;
         bitn  <= '0;
      end else if (take) begin
         so_d  <= nbuf[7];
         sr    <= {nbuf[6:0], 1'b0};
         bitn  <= '0;
         so_oe <= 1'b1;
      end else if (active && fall) begin
         so_d <= sr[7];
         sr   <= {sr[6:0], 1'b0};
         bitn <= bitn + 1'b1;
      end
   end

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
   import frd_pkg::*;
#(
   parameter int unsigned TOP_ADDR    = 32'h000F_FFFF,
   parameter int          SYNC_STAGES = 2,
   parameter int          DUMMY_BITS  = 8,
   localparam int         AW          = $clog2(TOP_ADDR + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sck,
   input  logic          si,
   output logic          so_d,
   output logic          so_oe,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   input  logic [7:0]    mem_rdata
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (TOP_ADDR < 1 || TOP_ADDR > 32'h00FF_FFFF) begin : g_bad_top
         $error("TOP_ADDR must fit the 24-bit wire address");
      end
      if (DUMMY_BITS < 1 || DUMMY_BITS > 32) begin : g_bad_dummy
         $error("DUMMY_BITS must be 1..32");
      end
   endgenerate

   logic                  cs_q;
   logic                  si_q;
   logic                  sck_rise;
   logic                  sck_fall;
   frd_state_e            state;
   logic                  addr_load;
   logic [WIRE_ABITS-1:0] addr_word;
   logic [AW-1:0]         ptr;

   frd_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sck      (sck),
      .si       (si),
      .cs_q     (cs_q),
      .si_q     (si_q),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall)
   );

   frd_header #(.DUMMY_BITS(DUMMY_BITS)) u_hdr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cs_q),
      .rise      (sck_rise),
      .si_q      (si_q),
      .state     (state),
      .addr_load (addr_load),
      .addr_word (addr_word)
   );

   frd_stream #(.TOP_ADDR(TOP_ADDR), .AW(AW)) u_str (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cs_q),
      .fall      (sck_fall),
      .active    (state == ST_DATA),
      .addr_load (addr_load),
      .load_addr (addr_word[AW-1:0]),
      .mem_rdata (mem_rdata),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .so_d      (so_d),
      .so_oe     (so_oe),
      .ptr       (ptr)
   );

endmodule

// File: rtl/flash_read_engine_chk.sv
module flash_read_engine_chk
   import frd_pkg::*;
#(
   parameter int unsigned TOP_ADDR = 32'h000F_FFFF,
   parameter int          AW       = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_q,
   input logic          sck_fall,
   input frd_state_e    state,
   input logic [AW-1:0] ptr,
   input logic          so_d,
   input logic          so_oe,
   input logic          mem_rd_en
);

   // R1: a deselected device releases its output on the next cycle
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !so_oe);

   // R7: no output drive outside the data phase
   assert_header_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_DATA) |-> !so_oe);

   // R8: output data moves only after a falling serial edge
   assert_fall_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(so_d));

   // R6: pointer steps by one and returns to zero after the top address
   assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_DATA && ptr != $past(ptr)) |->
      ptr == (($past(ptr) == AW'(TOP_ADDR)) ? '0 : $past(ptr) + 1'b1));

   // R9: a rejected command holds the engine until deselect
   assert_skip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && !cs_q) |=> (state == ST_SKIP));

   // R9: no array access after a rejected command
   assert_skip_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !mem_rd_en);

   // R11: read requests are single-cycle pulses
   assert_single_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

endmodule

bind flash_read_engine flash_read_engine_chk #(.TOP_ADDR(TOP_ADDR), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_q      (cs_q),
   .sck_fall  (sck_fall),
   .state     (state),
   .ptr       (ptr),
   .so_d      (so_d),
   .so_oe     (so_oe),
   .mem_rd_en (mem_rd_en)
);

// File: tb/flash_read_engine_test.sv
module flash_read_engine_test;

   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        si = 1'b0;
   logic        so_d;
   logic        so_oe;
   logic        mem_rd_en;
   logic [19:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;

   int n_checks = 0;
   int n_fail   = 0;
   int rd_cnt   = 0;
   int r8_viol  = 0;
   logic last_so = 1'b0;

   always #2 clk = ~clk;

   flash_read_engine uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sck       (sck),
      .si        (si),
      .so_d      (so_d),
      .so_oe     (so_oe),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [7:0] fbyte(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= fbyte(mem_addr);
         rd_cnt = rd_cnt + 1;
      end
      if (sck === 1'b1 && so_oe === 1'b1 && so_d !== last_so) r8_viol = r8_viol + 1;
      last_so = so_d;
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic xfer_bit(input logic b, output logic so_s, output logic oe_s);
      @(negedge clk);
      sck = 1'b0;
      si  = b;
      repeat (H) @(negedge clk);
      so_s = so_d;
      oe_s = so_oe;
      sck  = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic run_txn(input bit mode3, input logic [7:0] cmd, input logic [23:0] addr,
                          input int nbytes, input int tail_bits, input string rq);
      logic        b_so, b_oe, b;
      logic [7:0]  got;
      logic [19:0] ea;
      bit          fast, valid, hdr_oe, any_oe, oe_drop;
      int          hdr_bits, exp_rd;
      fast     = (cmd == 8'h0B);
      valid    = fast || (cmd == 8'h03);
      hdr_bits = fast ? 40 : 32;
      hdr_oe   = 0;
      any_oe   = 0;
      oe_drop  = 0;
      @(negedge clk);
      sck = mode3;
      repeat (3) @(negedge clk);
      rd_cnt  = 0;
      r8_viol = 0;
      cs_n    = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < hdr_bits; i++) begin
         if (i < 8)       b = cmd[7-i];
         else if (i < 32) b = addr[31-i];
         else             b = 1'(i);
         xfer_bit(b, b_so, b_oe);
         if (b_oe) hdr_oe = 1;
      end
      chk(!hdr_oe, "R7", "so_oe during header", longint'(hdr_oe), 0);
      ea = addr[19:0];
      for (int k = 0; k < nbytes; k++) begin
         got = '0;
         for (int j = 0; j < 8; j++) begin
            xfer_bit(1'(j ^ k), b_so, b_oe);
            got = {got[6:0], b_so};
            if (b_oe) any_oe = 1; else oe_drop = 1;
         end
         if (valid) chk(got == fbyte(ea), rq, "data byte", longint'(got), longint'(fbyte(ea)));
         ea = ea + 1'b1;
      end
      for (int t = 0; t < tail_bits; t++) xfer_bit(1'b1, b_so, b_oe);
      if (valid && nbytes > 0)
         chk(!oe_drop, "R5", "so_oe gap in data", longint'(oe_drop), 0);
      if (!valid)
         chk(!any_oe, "R9", "so_oe after unknown command", longint'(any_oe), 0);
      if (!mode3) begin
         @(negedge clk);
         sck = 1'b0;
         repeat (H) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(so_oe == 1'b0, "R1", "so_oe after deselect", longint'(so_oe), 0);
      chk(r8_viol == 0, "R8", "so_d changes while sck high", r8_viol, 0);
      if (valid)
         exp_rd = 1 + nbytes + ((tail_bits > 0) ? 1 : 0) +
                  ((!mode3 && tail_bits == 0 && nbytes > 0) ? 1 : 0);
      else
         exp_rd = 0;
      chk(rd_cnt == exp_rd, valid ? "R11" : "R9", "read pulse count", rd_cnt, exp_rd);
   endtask

   task automatic t_reset;
      repeat (2) @(negedge clk);
      chk(so_oe == 1'b0, "R1", "so_oe in reset", longint'(so_oe), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(so_oe == 1'b0, "R1", "so_oe after reset", longint'(so_oe), 0);
      chk(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", longint'(mem_rd_en), 0);
   endtask

   task automatic t_plain_read;
      run_txn(1'b0, 8'h03, 24'h012345, 6, 0, "R2 R5");
      run_txn(1'b1, 8'h03, 24'h0000F0, 3, 0, "R2 R8");
   endtask

   task automatic t_fast_read;
      run_txn(1'b1, 8'h0B, 24'h00ABCD, 4, 0, "R3 R8");
      run_txn(1'b0, 8'h0B, 24'h07FF00, 3, 0, "R3");
   endtask

   task automatic t_wrap;
      run_txn(1'b0, 8'h03, 24'h0FFFFE, 4, 0, "R6");
      run_txn(1'b1, 8'h0B, 24'h0FFFFF, 2, 0, "R6");
   endtask

   task automatic t_high_bits;
      run_txn(1'b1, 8'h03, 24'hA50010, 2, 0, "R4");
      run_txn(1'b0, 8'h0B, 24'hF0FFFF, 2, 0, "R4 R6");
   endtask

   task automatic t_bad_command;
      run_txn(1'b0, 8'h9F, 24'h000010, 3, 0, "R9");
      run_txn(1'b1, 8'h3B, 24'h000020, 2, 0, "R9");
      run_txn(1'b0, 8'h03, 24'h000030, 2, 0, "R9");
   endtask

   task automatic t_abort;
      run_txn(1'b0, 8'h03, 24'h000100, 2, 3, "R10");
      run_txn(1'b1, 8'h0B, 24'h000200, 2, 5, "R10");
      run_txn(1'b0, 8'h03, 24'h000300, 2, 0, "R10");
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_plain_read();
      t_fast_read();
      t_wrap();
      t_high_bits();
      t_bad_command();
      t_abort();
      finish_run();
   end

endmodule